// File: doc/BRIEF.md
# Memory-Mapped Signed Integer Divider

This block is a bus-attached divider for signed integers. Software writes a divisor into a holding register and then starts a division with a single write. A write to one start word runs a 32-by-32 divide of the written value. A write to the other start word runs a 64-by-32 divide whose upper half is taken from a staging word. When the operation completes, the quotient and remainder are copied into two result registers each, so either copy can be read.

The datapath works on magnitudes and retires a fixed number of quotient bits per cycle (`STEPS`). It then applies the signs and clamps a quotient that does not fit in 32 signed bits. Every operation takes the same number of cycles whatever the operands. A `busy` output is high during that time. A new start write always abandons the operation in progress and begins again with the new operands.

The bus uses word addresses: word index i is byte offset 4·i. Reads are combinational from `bus_addr`.

Top module: `sdiv_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable word returns 0 and `busy` is low.
- R2: Word 0 (byte 0x00) holds the divisor and reads back what was written. Words 2 and 3 always read 0, and writes to them have no effect.
- R3: A write to word 1 (byte 0x04) starts a 32/32 divide of the sign-extended written value. On completion, the quotient appears in words 1, 5 and 7 and the remainder in words 4 and 6.
- R4: A write to word 5 (byte 0x14) starts a 64/32 divide. The dividend's upper 32 bits come from word 4 (byte 0x10) and its lower 32 bits are the written value. On completion, the quotient appears in words 5 and 7 and the remainder in words 4 and 6. Word 1 is not changed.
- R5: The quotient is truncated toward zero. A nonzero remainder carries the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R6: In either mode, a quotient above 2^31−1 reads 0x7FFFFFFF and a quotient below −2^31 reads 0x80000000. The remainder keeps its true value.
- R7: With a zero divisor, words 4, 5, 6 and 7 become 0. In 32/32 mode, word 1 keeps the written dividend.
- R8: `busy` rises on the edge that takes a start write and falls exactly 2·DW/STEPS+1 edges later (33 with the default parameters). Until then, the operation changes no result word, so reads return the earlier contents or the word's last written value.
- R9: A start write while `busy` is high abandons the running operation. The full latency is counted again from the new write, and only the new operands' results are stored.
- R10: A start write on the same edge on which a running operation would store its results takes priority. The old results are never stored.
- R11: A plain write to word 4, 6 or 7 while `busy` is high is stored and reads back. On the completion edge, the results take priority over a simultaneous plain write.
- R12: Right after completion, word 6 equals word 4 and word 7 equals word 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 3 | Word index for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| busy | output | 1 | High while a divide is in progress |

## Verification
Two events can land on the same clock edge: a running divide storing its results, and a new bus write. The bench places a second start write exactly on the completion edge. It then checks that `busy` stays high for a full new latency and that the first operation's remainder never reaches the result words. A second case places a plain write to a mirror word on the completion edge and expects the computed remainder to replace it. The bench judges both cases against a reference divider built on 64-bit integer arithmetic with explicit clamping.

// File: rtl/sdiv_pkg.sv
// Package: sdiv_pkg
// Word map and decode helpers shared by the divider modules.
// Assumes a word-addressed bus of ADDR_W bits.
package sdiv_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] W_DIVISOR = 3'd0;
    localparam logic [ADDR_W-1:0] W_START32 = 3'd1;
    localparam logic [ADDR_W-1:0] W_REM     = 3'd4;
    localparam logic [ADDR_W-1:0] W_START64 = 3'd5;
    localparam logic [ADDR_W-1:0] W_REM_CPY = 3'd6;
    localparam logic [ADDR_W-1:0] W_QUO_CPY = 3'd7;

    // True for the two words whose write launches a divide.
    function automatic logic is_start(input logic [ADDR_W-1:0] a);
        return (a == W_START32) || (a == W_START64);
    endfunction
endpackage

// File: rtl/sdiv_ctrl.sv
// Module: sdiv_ctrl
// Sequencer. It counts ITER step cycles after a start and then raises a
// one-cycle commit. A start always restarts the count and suppresses commit.
// Assumes ITER >= 1.
module sdiv_ctrl #(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic step,
    output logic commit
);
    localparam int CW = $clog2(ITER + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(ITER);

    logic [CW-1:0] cnt;

    // Busy flag and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CNT_LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Step and commit strobes; a start beats both.
    always_comb begin
        step   = busy && !start && (cnt != CNT_LAST);
        commit = busy && !start && (cnt == CNT_LAST);
    end

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt == '0));
    assert_commit_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    assert_count_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == $past(cnt) + 1'b1));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy && cnt == '0));
endmodule

// File: rtl/sdiv_engine.sv
// Module: sdiv_engine
// Iterative restoring divider on magnitudes. STEPS quotient bits are retired
// per step cycle through a generated chain of compare/subtract stages. The
// signed quotient (clamped to DW signed bits) and the signed remainder are
// formed combinationally from the state.
// Assumes (2*DW) % STEPS == 0.
module sdiv_engine #(
    parameter int DW    = 32,
    parameter int STEPS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          long_mode,
    input  logic [DW-1:0] hi_word,
    input  logic [DW-1:0] lo_word,
    input  logic [DW-1:0] divisor,
    input  logic          step,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem,
    output logic          div_zero,
    output logic          ovf
);
    localparam int NW = 2 * DW;
    localparam logic [NW-1:0] POS_LIM = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [NW-1:0] NEG_LIM = {{DW{1'b0}}, 1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SAT_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [NW-1:0] acc;
    logic [DW-1:0] prem;
    logic [DW-1:0] dmag;
    logic          qneg, rneg;

    logic [NW-1:0] num;
    logic [NW-1:0] num_mag;
    logic [DW-1:0] den_mag;

    // Operand sign handling at load time.
    always_comb begin
        num     = long_mode ? {hi_word, lo_word} : {{DW{lo_word[DW-1]}}, lo_word};
        num_mag = num[NW-1] ? (~num + 1'b1) : num;
        den_mag = divisor[DW-1] ? (~divisor + 1'b1) : divisor;
    end

    logic [NW-1:0] a_ch [0:STEPS];
    logic [DW-1:0] r_ch [0:STEPS];

    assign a_ch[0] = acc;
    assign r_ch[0] = prem;

    for (genvar g = 0; g < STEPS; g++) begin : g_stage
        logic [DW:0] trial;
        logic        fits;
        // One restoring step: shift in a dividend bit, subtract if it fits.
        always_comb begin
            trial = {r_ch[g], a_ch[g][NW-1]};
            fits  = (trial >= {1'b0, dmag});
            a_ch[g+1] = {a_ch[g][NW-2:0], fits};
            r_ch[g+1] = fits ? (trial[DW-1:0] - dmag) : trial[DW-1:0];
        end
    end

    // Engine state: load operands or advance STEPS bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            prem     <= '0;
            dmag     <= '0;
            qneg     <= 1'b0;
            rneg     <= 1'b0;
            div_zero <= 1'b1;
        end else if (load) begin
            acc      <= num_mag;
            prem     <= '0;
            dmag     <= den_mag;
            qneg     <= num[NW-1] ^ divisor[DW-1];
            rneg     <= num[NW-1];
            div_zero <= (divisor == '0);
        end else if (step) begin
            acc  <= a_ch[STEPS];
            prem <= r_ch[STEPS];
        end
    end

    // Signed results with quotient clamping.
    always_comb begin
        ovf  = qneg ? (acc > NEG_LIM) : (acc > POS_LIM);
        if (ovf)
            quot = qneg ? SAT_NEG : SAT_POS;
        else
            quot = qneg ? (~acc[DW-1:0] + 1'b1) : acc[DW-1:0];
        rem = rneg ? (~prem + 1'b1) : prem;
    end

    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !div_zero |-> (prem < dmag));
    assert_rem_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_zero && prem != '0) |-> (rem[DW-1] == rneg));
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (quot == SAT_POS || quot == SAT_NEG));
endmodule

// File: rtl/sdiv_regfile.sv
// Module: sdiv_regfile
// Bus-visible words: divisor, 32-bit dividend/quotient, staging high word and
// the mirrored result pairs. A commit overrides a same-cycle plain write.
// Assumes a commit never coincides with a start write, which the sequencer
// guarantees.
module sdiv_regfile
    import sdiv_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic              commit,
    input  logic [DW-1:0]     res_q,
    input  logic [DW-1:0]     res_r,
    input  logic              res_zero,
    output logic [DW-1:0]     divisor,
    output logic [DW-1:0]     hi_word
);
    logic [DW-1:0] w1, w4, w5, w6, w7;
    logic          mode_long;

    logic [DW-1:0] q_store, r_store;

    // Results as stored: zeroed on a zero divisor.
    always_comb begin
        q_store = res_zero ? '0 : res_q;
        r_store = res_zero ? '0 : res_r;
    end

    // Divisor word and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor   <= '0;
            mode_long <= 1'b0;
        end else if (wr) begin
            if (addr == W_DIVISOR) divisor <= wdata;
            if (addr == W_START32) mode_long <= 1'b0;
            if (addr == W_START64) mode_long <= 1'b1;
        end
    end

    // Word 1: written dividend, then quotient in 32/32 mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            w1 <= '0;
        else if (commit && !mode_long && !res_zero)
            w1 <= q_store;
        else if (wr && addr == W_START32)
            w1 <= wdata;
    end

    // Result words and their copies; commit beats plain writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w4 <= '0;
            w5 <= '0;
            w6 <= '0;
            w7 <= '0;
        end else if (commit) begin
            w4 <= r_store;
            w6 <= r_store;
            w5 <= q_store;
            w7 <= q_store;
        end else if (wr) begin
            case (addr)
                W_REM:     w4 <= wdata;
                W_START64: w5 <= wdata;
                W_REM_CPY: w6 <= wdata;
                W_QUO_CPY: w7 <= wdata;
                default:   ;
            endcase
        end
    end

    assign hi_word = w4;

    // Read multiplexer.
    always_comb begin
        case (addr)
            W_DIVISOR: rdata = divisor;
            W_START32: rdata = w1;
            W_REM:     rdata = w4;
            W_START64: rdata = w5;
            W_REM_CPY: rdata = w6;
            W_QUO_CPY: rdata = w7;
            default:   rdata = '0;
        endcase
    end

    assert_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (w4 == w6 && w5 == w7));
    assert_zero_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && res_zero) |=> (w4 == '0 && w5 == '0));
    assert_keep_dividend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && res_zero) |=> $stable(w1));
    assert_long_keeps_w1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && mode_long) |=> $stable(w1));
endmodule

// File: rtl/sdiv_unit.sv
// Module: sdiv_unit (top)
// Memory-mapped signed divider with 32/32 and 64/32 modes. A write to a start
// word loads the engine and (re)starts the sequencer. After ITER step cycles
// one commit cycle stores the results.
// Assumes DW = 32 for the bus map and (2*DW) % STEPS == 0.
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int DW    = 32,
    parameter int STEPS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              busy
);
    localparam int ITER = (2 * DW) / STEPS;

    logic          start, long_sel, step, commit;
    logic [DW-1:0] divisor, hi_word, res_q, res_r;
    logic          res_zero, res_ovf;

    // Start decode from the bus.
    always_comb begin
        start    = bus_wr && is_start(bus_addr);
        long_sel = (bus_addr == W_START64);
    end

    sdiv_ctrl #(.ITER(ITER)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .step   (step),
        .commit (commit)
    );

    sdiv_engine #(.DW(DW), .STEPS(STEPS)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .long_mode (long_sel),
        .hi_word   (hi_word),
        .lo_word   (bus_wdata),
        .divisor   (divisor),
        .step      (step),
        .quot      (res_q),
        .rem       (res_r),
        .div_zero  (res_zero),
        .ovf       (res_ovf)
    );

    sdiv_regfile #(.DW(DW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .commit   (commit),
        .res_q    (res_q),
        .res_r    (res_r),
        .res_zero (res_zero),
        .divisor  (divisor),
        .hi_word  (hi_word)
    );

    assert_commit_needs_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);
    assert_ovf_quot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && res_ovf && !res_zero) |=> (bus_addr != W_QUO_CPY || bus_wr ||
            bus_rdata == {1'b0, {(DW-1){1'b1}}} || bus_rdata == {1'b1, {(DW-1){1'b0}}}));
endmodule

// File: tb/test_sdiv_unit.sv
// Directed bench for sdiv_unit. Inputs change at falling edges and outputs
// are sampled at falling edges. Every task is entered and left at a falling edge.
module test_sdiv_unit;
    localparam int LAT = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdiv_unit i_sdiv_unit (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic void ref_div(input bit is64, input logic [31:0] hi, input logic [31:0] lo,
                                    input logic [31:0] dv, output logic [31:0] q, output logic [31:0] r);
        longint n, d, qq, rr, lim;
        lim = 64'sh7FFFFFFF;
        n = is64 ? longint'({hi, lo}) : longint'($signed(lo));
        d = longint'($signed(dv));
        if (d == 0) begin
            q = '0; r = '0;
            return;
        end
        qq = n / d;
        rr = n % d;
        if (qq > lim) q = 32'h7FFFFFFF;
        else if (qq < -lim - 1) q = 32'h80000000;
        else q = qq[31:0];
        r = rr[31:0];
    endfunction

    // Checks every result word against the reference model.
    task automatic check_results(input string req, input bit is64, input logic [31:0] hi,
                                 input logic [31:0] lo, input logic [31:0] dv,
                                 input logic [31:0] w1_before);
        logic [31:0] q, r, v;
        ref_div(is64, hi, lo, dv, q, r);
        rd(3'd4, v); check({req, " remainder w4 (R5)"}, v, r);
        rd(3'd6, v); check({req, " remainder copy w6 (R12)"}, v, r);
        rd(3'd5, v); check({req, " quotient w5 (R5)"}, v, q);
        rd(3'd7, v); check({req, " quotient copy w7 (R12)"}, v, q);
        rd(3'd1, v);
        if (is64) check({req, " w1 untouched (R4)"}, v, w1_before);
        else if (dv == 0) check({req, " w1 keeps dividend (R7)"}, v, lo);
        else check({req, " quotient w1 (R3)"}, v, q);
    endtask

    // Full divide: load operands, start, measure latency, check results.
    task automatic run_div(input string req, input bit is64, input logic [31:0] hi,
                           input logic [31:0] lo, input logic [31:0] dv);
        logic [31:0] w1b;
        int n;
        wr(3'd0, dv);
        if (is64) wr(3'd4, hi);
        rd(3'd1, w1b);
        @(negedge clk);
        wr(is64 ? 3'd5 : 3'd1, lo);
        wait_idle(n);
        check({req, " latency (R8)"}, n, LAT);
        check_results(req, is64, hi, lo, dv, w1b);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R1 word after reset", v, 32'd0);
        end
    endtask

    task automatic t_plain_regs;
        logic [31:0] v;
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, v); check("R2 divisor readback", v, 32'h1234_5678);
        @(negedge clk);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hAAAA_5555);
        rd(3'd2, v); check("R2 word2 reads zero", v, 32'd0);
        rd(3'd3, v); check("R2 word3 reads zero", v, 32'd0);
        check("R2 no start from word2/3", {31'd0, busy}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_div32;
        run_div("R3 100/7", 1'b0, 0, 32'd100, 32'd7);
        run_div("R3 -100/7", 1'b0, 0, -32'sd100, 32'd7);
        run_div("R5 100/-7", 1'b0, 0, 32'd100, -32'sd7);
        run_div("R5 -100/-7", 1'b0, 0, -32'sd100, -32'sd7);
        run_div("R3 max/1", 1'b0, 0, 32'h7FFFFFFF, 32'd1);
        run_div("R5 small/big", 1'b0, 0, -32'sd3, 32'h7FFFFFFF);
    endtask

    task automatic t_div64;
        run_div("R4 2^32/3", 1'b1, 32'd1, 32'd0, 32'd3);
        run_div("R4 neg 64", 1'b1, 32'hFFFFFFFE, 32'h0000_0005, 32'd7);
        run_div("R4 neg divisor", 1'b1, 32'd0, 32'h8000_0000, 32'hFFFF_FFFF);
        run_div("R4 min divisor", 1'b1, 32'h1, 32'h0000_0000, 32'h8000_0000);
    endtask

    task automatic t_saturate;
        run_div("R6 pos ovf 64", 1'b1, 32'h10, 32'd0, 32'd2);
        run_div("R6 neg ovf 64", 1'b1, 32'hFFFFFFF0, 32'd0, 32'd3);
        run_div("R6 2^31/1", 1'b1, 32'd0, 32'h8000_0000, 32'd1);
        run_div("R6 min/-1 32", 1'b0, 0, 32'h8000_0000, 32'hFFFF_FFFF);
    endtask

    task automatic t_zero;
        run_div("R7 zero 32", 1'b0, 0, 32'hDEAD_0001, 32'd0);
        run_div("R3 restore", 1'b0, 0, 32'd50, 32'd9);
        run_div("R7 zero 64", 1'b1, 32'h5, 32'h77, 32'd0);
    endtask

    // R8 stale reads and R11 plain writes during busy.
    task automatic t_stale;
        logic [31:0] v, prev_r;
        int n;
        run_div("R8 prep", 1'b0, 0, 32'd23, 32'd5);
        rd(3'd6, prev_r);
        @(negedge clk);
        wr(3'd1, 32'd1000);
        rd(3'd6, v); check("R8 stale remainder during busy", v, prev_r);
        rd(3'd1, v); check("R8 w1 shows written value", v, 32'd1000);
        @(negedge clk);
        wr(3'd4, 32'hCAFE_0001);
        rd(3'd4, v); check("R11 plain write during busy", v, 32'hCAFE_0001);
        check("R11 plain write keeps busy", {31'd0, busy}, 32'd1);
        wait_idle(n);
        check_results("R11 after plain write", 1'b0, 0, 32'd1000, 32'd5, 32'd0);
    endtask

    // R9 abort and restart.
    task automatic t_abort;
        int n;
        wr(3'd0, 32'd13);
        @(negedge clk);
        wr(3'd1, 32'd999);
        repeat (10) @(negedge clk);
        wr(3'd1, -32'sd77);
        wait_idle(n);
        check("R9 full latency after restart", n, LAT);
        check_results("R9 restarted op", 1'b0, 0, -32'sd77, 32'd13, 32'd0);
    endtask

    // R10 start on the commit edge; R11 plain write on the commit edge.
    task automatic t_collide;
        logic [31:0] v, old_r;
        int n;
        run_div("R10 prep", 1'b0, 0, 32'd17, 32'd4);
        rd(3'd6, old_r);
        @(negedge clk);
        wr(3'd0, 32'd6);
        wr(3'd1, 32'd29);
        repeat (LAT - 1) @(negedge clk);
        wr(3'd1, 32'd44);
        check("R10 busy held by new start", {31'd0, busy}, 32'd1);
        rd(3'd6, v); check("R10 old result not stored", v, old_r);
        wait_idle(n);
        check("R10 latency of new op", n, LAT);
        check_results("R10 new op", 1'b0, 0, 32'd44, 32'd6, 32'd0);
        @(negedge clk);
        wr(3'd1, -32'sd45);
        repeat (LAT - 1) @(negedge clk);
        wr(3'd6, 32'hDEAD_BEEF);
        check("R11 idle after commit", {31'd0, busy}, 32'd0);
        check_results("R11 commit beats write", 1'b0, 0, -32'sd45, 32'd6, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_regs();
        t_div32();
        t_div64();
        t_saturate();
        t_zero();
        t_stale();
        t_abort();
        t_collide();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule